// File: doc/BRIEF.md
# Predicated Vector Multiply-Add Lane Unit

This block performs an integer multiply-accumulate or multiply-subtract on every element of a fixed-width vector in one step. Each element position has its own lane. A caller presents three vector operands, a byte-granular predicate, an element-size code and a 3-bit operation selector. One cycle after the operation is accepted, the block returns the new value of the destination register.

The destination operand `dst_vec` is the old contents of the register that the operation overwrites. In the accumulate forms that register is the addend. In the overwrite-multiplicand forms it is the multiplicand, and `src_vec` then supplies the addend. Elements whose predicate is clear pass `dst_vec` through unchanged. All arithmetic is truncated to the element width, so signed and unsigned operands produce the same bits and no overflow indication exists.

A single output register holds the result behind a valid/ready handshake. The block accepts a new operation only while that register is empty or is being drained in the same cycle.

Top module: `pred_muladd_vec`

## Requirements
- R1: For an active element of the add forms, the result is addend + multiplicand*multiplier, truncated to the element width (wraps modulo 2^width).
- R2: For an active element of the subtract forms, the result is addend - multiplicand*multiplier, truncated to the element width.
- R3: `size_code` sets the element width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits.
- R4: `pred` has one bit per vector byte. An element is active only when the bit of its lowest-addressed byte is 1. The other predicate bits of that element are ignored.
- R5: An inactive element returns the matching bits of `dst_vec` unchanged.
- R6: `op_sel` decodes as follows:
  - 010 is multiply-add and 011 is multiply-subtract. In both, `dst_vec` is the addend and `src_vec` is the multiplicand.
  - 110 is multiply-add and 111 is multiply-subtract. In both, `dst_vec` is the multiplicand and `src_vec` is the addend.
  - Any selector with bit 1 clear returns `dst_vec` unchanged in every element.
- R7: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R8: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result appears on `out_vec` with `out_valid` high after that edge. `out_vec` and `out_valid` then hold until `out_ready` is 1. `in_ready` is 1 exactly when the output is empty or `out_ready` is 1.
- R9: Elements are laid out little-endian. Element i occupies bits [i*W +: W], where W is the element width, and is tested through predicate bit i*W/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted |
| op_sel | input | 3 | Operation selector |
| size_code | input | 2 | Element size code |
| dst_vec | input | VEC_W | Old contents of the destination register |
| src_vec | input | VEC_W | Multiplicand (010/011) or addend (110/111) |
| mul_vec | input | VEC_W | Multiplier |
| pred | input | VEC_W/8 | Byte predicate |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | VEC_W | New destination register value |

## Verification
A lane that is wired to the wrong byte offset, that tests the wrong predicate bit, or that swaps addend and multiplicand corrupts a particular element. That fault shows on `out_vec` in the first cycle after the operation is accepted. The bench compares every element against a model, so it locates such a fault at once. A fault in the output register shows up differently: a result is overwritten while it is stalled, or `out_valid` is dropped early. This appears within one cycle of a stall, and the handshake sequence forces exactly that situation. The predicate patterns set only the non-lowest bits of each element, so a lane that tests the wrong predicate bit changes an element that must stay untouched.

// File: rtl/pred_muladd_vec.sv
module pred_muladd_vec #(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [2:0]         op_sel,
  input  logic [1:0]         size_code,
  input  logic [VEC_W-1:0]   dst_vec,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W-1:0]   mul_vec,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_vec
);
  localparam int NSIZE = 4;

  logic             do_sub, swap_dst, legal, accept;
  logic [VEC_W-1:0] addend, mcand;
  logic [VEC_W-1:0] res [NSIZE];

  assign do_sub   = op_sel[0];
  assign legal    = op_sel[1];
  assign swap_dst = op_sel[2];
  assign addend   = swap_dst ? src_vec : dst_vec;
  assign mcand    = swap_dst ? dst_vec : src_vec;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int NE = VEC_W / EW;
    logic [VEC_W-1:0] v;
    always_comb begin
      v = dst_vec;
      for (int e = 0; e < NE; e++) begin
        logic [EW-1:0] p;
        p = mcand[e*EW +: EW] * mul_vec[e*EW +: EW];
        if (legal && pred[e*(EW/8)])
          v[e*EW +: EW] = do_sub ? addend[e*EW +: EW] - p
                                 : addend[e*EW +: EW] + p;
      end
    end
    assign res[s] = v;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_vec   <= res[size_code];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pred_muladd_vec_chk.sv
module pred_muladd_vec_chk #(
  parameter int VEC_W = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [2:0]         op_sel,
  input logic [1:0]         size_code,
  input logic [VEC_W-1:0]   dst_vec,
  input logic [VEC_W-1:0]   mul_vec,
  input logic [VEC_W/8-1:0] pred,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VEC_W-1:0]   out_vec
);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r6_illegal_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !op_sel[1] |=> out_vec == $past(dst_vec));

  a_r5_all_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && pred == '0 |=> out_vec == $past(dst_vec));

  a_r1_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_sel == 3'b010 && mul_vec == '0
    |=> out_vec == $past(dst_vec));

  a_r4_high_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && size_code == 2'd3 &&
    pred[0] == 1'b0 && pred[8] == 1'b0
    |=> out_vec == $past(dst_vec));
endmodule

bind pred_muladd_vec pred_muladd_vec_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_sel(op_sel), .size_code(size_code), .dst_vec(dst_vec),
  .mul_vec(mul_vec), .pred(pred), .out_valid(out_valid),
  .out_ready(out_ready), .out_vec(out_vec)
);

// File: tb/test_pred_muladd_vec.sv
module test_pred_muladd_vec;
  localparam int W  = 128;
  localparam int NB = W / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [2:0]    op_sel = '0;
  logic [1:0]    size_code = '0;
  logic [W-1:0]  dst_vec = '0, src_vec = '0, mul_vec = '0, out_vec;
  logic [NB-1:0] pred = '0;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pred_muladd_vec #(.VEC_W(W)) i_pred_muladd_vec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .size_code(size_code), .dst_vec(dst_vec),
    .src_vec(src_vec), .mul_vec(mul_vec), .pred(pred),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec)
  );

  // stimulus table: {op_sel, size_code, pred, seed}
  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [15:0] pr;
    logic [31:0] seed;
  } stim_t;

  localparam stim_t TABLE [20] = '{
    '{3'b010, 2'd0, 16'hFFFF, 32'h1234_5678}, '{3'b011, 2'd0, 16'hAAAA, 32'h0BAD_F00D},
    '{3'b110, 2'd0, 16'h5555, 32'hDEAD_BEEF}, '{3'b111, 2'd0, 16'hFFFF, 32'h0000_0F0F},
    '{3'b010, 2'd1, 16'h5555, 32'hCAFE_0001}, '{3'b011, 2'd1, 16'hAAAA, 32'h1357_9BDF},
    '{3'b110, 2'd1, 16'hFFFF, 32'h2468_ACE0}, '{3'b111, 2'd1, 16'h3333, 32'h7777_1111},
    '{3'b010, 2'd2, 16'h1111, 32'h0102_0304}, '{3'b011, 2'd2, 16'hEEEE, 32'h5A5A_A5A5},
    '{3'b110, 2'd2, 16'hFFFF, 32'h9999_0001}, '{3'b111, 2'd2, 16'h0F0F, 32'h4321_8765},
    '{3'b010, 2'd3, 16'h0101, 32'hFEED_FACE}, '{3'b011, 2'd3, 16'hFFFF, 32'h3141_5926},
    '{3'b110, 2'd3, 16'hFEFE, 32'h2718_2818}, '{3'b111, 2'd3, 16'h00FF, 32'h1618_0339},
    '{3'b000, 2'd0, 16'hFFFF, 32'h0A0B_0C0D}, '{3'b101, 2'd2, 16'hFFFF, 32'h1111_2222},
    '{3'b010, 2'd0, 16'h0000, 32'h7654_3210}, '{3'b111, 2'd3, 16'h0000, 32'h0F1E_2D3C}
  };

  function automatic logic [W-1:0] gen_vec(input logic [31:0] seed);
    logic [31:0] x = seed | 32'h1;
    logic [W-1:0] v = '0;
    for (int k = 0; k < W/32; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      v[k*32 +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [W-1:0] model(input logic [2:0] op, input logic [1:0] sz,
      input logic [NB-1:0] pr, input logic [W-1:0] d, input logic [W-1:0] s,
      input logic [W-1:0] m);
    int ew = 8 << sz;
    logic [63:0] msk = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
    logic [W-1:0] r = d;
    for (int e = 0; e < W/ew; e++) begin
      logic [63:0] dv, sv, mv, av, nv, val;
      dv = 64'(d >> (e*ew)) & msk;
      sv = 64'(s >> (e*ew)) & msk;
      mv = 64'(m >> (e*ew)) & msk;
      if (op[2]) begin nv = dv; av = sv; end else begin av = dv; nv = sv; end
      if (op[1] && pr[e*ew/8]) begin
        val = (op[0] ? av - nv*mv : av + nv*mv) & msk;
        r = (r & ~({{(W-64){1'b0}}, msk} << (e*ew))) | ({{(W-64){1'b0}}, val} << (e*ew));
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [1:0] sz,
      input logic [NB-1:0] pr, input logic [W-1:0] d, input logic [W-1:0] s,
      input logic [W-1:0] m, input string req);
    logic [W-1:0] exp;
    exp = model(op, sz, pr, d, s, m);
    @(negedge clk);
    op_sel = op; size_code = sz; pred = pr;
    dst_vec = d; src_vec = s; mul_vec = m;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_vec == exp, req, out_vec, exp);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] first, second;
    // R7: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R7 reset state", {126'b0, out_valid, in_ready}, 128'h1);
    rst_n = 1'b1;

    // Table walk: R1 R2 R3 R4 R5 R6 R9 against the model
    foreach (TABLE[i]) begin
      run_op(TABLE[i].op, TABLE[i].sz, TABLE[i].pr, gen_vec(TABLE[i].seed),
             gen_vec(TABLE[i].seed ^ 32'h5555_0000), gen_vec(TABLE[i].seed + 32'd77),
             "R1/R2/R3/R6 table");
    end

    // R1: 8-bit add with hand value: 5 + 3*4 = 0x11 per byte
    run_op(3'b010, 2'd0, '1, {NB{8'h05}}, {NB{8'h03}}, {NB{8'h04}}, "R1 byte add");
    check(out_vec == {NB{8'h11}}, "R1 literal", out_vec, {NB{8'h11}});
    // R1 wrap: 1 + 0x10*0x10 wraps to 0x01
    run_op(3'b010, 2'd0, '1, {NB{8'h01}}, {NB{8'h10}}, {NB{8'h10}}, "R1 wrap");
    check(out_vec == {NB{8'h01}}, "R1 wrap literal", out_vec, {NB{8'h01}});
    // R2: 0 - 1*1 wraps to all ones in 16-bit lanes
    run_op(3'b011, 2'd1, '1, '0, {8{16'h0001}}, {8{16'h0001}}, "R2 sub wrap");
    check(out_vec == '1, "R2 literal", out_vec, '1);
    // R6: multiplicand-overwrite form 32-bit: dst=n=2, src=a=7, m=3 -> 13
    run_op(3'b110, 2'd2, '1, {4{32'd2}}, {4{32'd7}}, {4{32'd3}}, "R6 mad");
    check(out_vec == {4{32'd13}}, "R6 mad literal", out_vec, {4{32'd13}});
    // R4: only non-lowest bits set in 16-bit elements -> all inactive
    run_op(3'b010, 2'd1, 16'hAAAA, gen_vec(32'h11), gen_vec(32'h22), gen_vec(32'h33), "R4 odd bits");
    check(out_vec == gen_vec(32'h11), "R4 ignored bits", out_vec, gen_vec(32'h11));
    // R4/R9: 64-bit, only upper element's low bit -> only bits 127:64 change
    run_op(3'b010, 2'd3, 16'h0100, {64'd1, 64'd1}, {64'd2, 64'd2}, {64'd3, 64'd3}, "R9 upper lane");
    check(out_vec == {64'd7, 64'd1}, "R9 literal", out_vec, {64'd7, 64'd1});
    // R5: inactive 64-bit lanes keep dst
    run_op(3'b111, 2'd3, 16'hFEFE, gen_vec(32'h44), gen_vec(32'h55), gen_vec(32'h66), "R5 inactive");
    check(out_vec == gen_vec(32'h44), "R5 keep dst", out_vec, gen_vec(32'h44));

    // R8: stall holds result and blocks new work
    first  = model(3'b010, 2'd0, '1, {NB{8'h02}}, {NB{8'h02}}, {NB{8'h02}});
    second = model(3'b011, 2'd0, '1, {NB{8'h09}}, {NB{8'h02}}, {NB{8'h02}});
    @(negedge clk);
    op_sel = 3'b010; size_code = 2'd0; pred = '1;
    dst_vec = {NB{8'h02}}; src_vec = {NB{8'h02}}; mul_vec = {NB{8'h02}};
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check(out_valid && !in_ready && out_vec == first, "R8 stall accept", out_vec, first);
    op_sel = 3'b011; dst_vec = {NB{8'h09}};
    @(negedge clk);
    check(out_valid && out_vec == first, "R8 stall hold", out_vec, first);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8 ready on drain", {127'b0, in_ready}, 128'h1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_vec == second, "R8 drain and accept", out_vec, second);
    @(negedge clk);
    check(!out_valid, "R8 emptied", {127'b0, out_valid}, 128'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule